// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one event channel of a platform timer. A free-running main counter elsewhere in the timer supplies its value and a tick qualifier to the channel. The channel compares that value with its own programmed comparator. When the two are equal on a tick cycle, and the timer as a whole is enabled, the channel reports a match. The match sets a per-channel status flag and can raise an interrupt, either as a held level or as a single-cycle edge.

In one-shot mode the comparator keeps its value after a match, so the event happens once. In periodic mode the channel adds a stored period to the comparator after every match, so events repeat without software help. When software writes the comparator while periodic mode is selected, the written value also becomes the period. A forced 32-bit mode limits both the compare and the periodic advance to the low half of the counter. A 5-bit route field and a message-delivery enable are held in the configuration and brought out for downstream logic, which lies outside this block.

The surrounding core decodes register accesses and presents them as write strobes with data. The status flag is cleared through a separate clear strobe.

Top module: `tmr_chan`

## Requirements
- R1: Configuration writes keep only bit 1 (trigger: 0 edge, 1 level), bit 2 (interrupt enable), bit 3 (periodic when 1), bit 8 (forced 32-bit), bits 13:9 (route) and bit 14 (message enable). All other bits read 0. `route_o` carries bits 13:9 and `msg_en_o` carries bit 14. After reset the configuration is 0 and the comparator is all ones.
- R2: `sts_set_o` is high, in the same cycle, exactly when `glb_en_i` and `cnt_tick_i` are both high and the counter equals the comparator.
- R3: No match is taken while `glb_en_i` is low or while `cnt_tick_i` is low, even when the counter equals the comparator.
- R4: A match sets `sts_o` on the following cycle whether or not interrupts are enabled. `sts_clr_i` clears the flag, and a match in the same cycle takes priority over the clear.
- R5: In one-shot mode a match leaves the comparator unchanged, so a counter that keeps rising fires only once.
- R6: In periodic mode every match adds the period to the comparator on the next edge. A comparator write in periodic mode also loads the period. A write in one-shot mode leaves the period unchanged.
- R7: In forced 32-bit mode only bits 31:0 of the counter and comparator are compared. The periodic advance wraps within bits 31:0 and keeps comparator bits 63:32.
- R8: In level mode `irq_o` equals the status flag ANDed with the interrupt enable, so it stays high until the flag is cleared.
- R9: In edge mode with interrupts enabled, each match gives a one-cycle `irq_o` pulse on the following cycle. Back-to-back matches give back-to-back pulses.
- R10: A comparator write in the same cycle as a periodic match takes priority over the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Timer-wide enable |
| cnt_tick_i | input | 1 | Main counter advances this cycle |
| cnt_i | input | 64 | Main counter value |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| cmp_we_i | input | 1 | Comparator write strobe |
| cmp_wdata_i | input | 64 | Comparator write data |
| sts_clr_i | input | 1 | Clear the status flag |
| cfg_o | output | 16 | Stored configuration |
| cmp_o | output | 64 | Current comparator value |
| route_o | output | 5 | Stored route field |
| msg_en_o | output | 1 | Stored message-delivery enable |
| sts_set_o | output | 1 | Match pulse toward the status register |
| sts_o | output | 1 | Status flag |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench drives a rising counter through one-shot fires. If the comparator advanced in one-shot mode, a second fire would appear. It runs periodic sequences and checks that each advance uses the period captured at the last periodic write and not a later one-shot write; a wrong capture would space the matches incorrectly. It places the counter on the comparator value while the timer-wide enable or the tick is low, which catches a match that ignores either qualifier. It also raises a clear in the same cycle as a match, which catches a flag left low because the clear won. In forced 32-bit mode, the counter's upper half differs from the comparator's and the low half wraps. A full-width compare would never fire there, and an advance that carries into the upper half would leave the comparator at the wrong value.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int CFG_W   = 16;
  localparam int ROUTE_W = 5;

  localparam int B_LEVEL = 1;
  localparam int B_IE    = 2;
  localparam int B_PER   = 3;
  localparam int B_M32   = 8;
  localparam int B_ROUTE = 9;
  localparam int B_MSG   = 14;

  localparam logic [CFG_W-1:0] CFG_MASK =
    CFG_W'((1 << B_LEVEL) | (1 << B_IE) | (1 << B_PER) | (1 << B_M32) |
           (((1 << ROUTE_W) - 1) << B_ROUTE) | (1 << B_MSG));

  typedef struct packed {
    logic               level;
    logic               ie;
    logic               periodic;
    logic               m32;
    logic [ROUTE_W-1:0] route;
    logic               msg_en;
  } cfg_t;
endpackage

// File: rtl/tmr_chan_cfg.sv
module tmr_chan_cfg
  import tmr_chan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output cfg_t             dec_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i & CFG_MASK;
  end

  assign cfg_o          = cfg_q;
  assign dec_o.level    = cfg_q[B_LEVEL];
  assign dec_o.ie       = cfg_q[B_IE];
  assign dec_o.periodic = cfg_q[B_PER];
  assign dec_o.m32      = cfg_q[B_M32];
  assign dec_o.route    = cfg_q[B_ROUTE +: ROUTE_W];
  assign dec_o.msg_en   = cfg_q[B_MSG];

  p_cfg_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cfg_q == ($past(wdata_i) & CFG_MASK));
endmodule

// File: rtl/tmr_chan_cmp.sv
module tmr_chan_cmp #(
  parameter int CNT_W = 64,
  parameter int LOW_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glb_en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             periodic_i,
  input  logic             m32_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             match_o
);
  localparam int HI_W = CNT_W - LOW_W;

  logic [CNT_W-1:0] cmp_q, per_q, adv_full, adv_low, adv;
  logic             eq_full, eq_low;

  assign eq_full = (cnt_i == cmp_q);
  assign eq_low  = (cnt_i[LOW_W-1:0] == cmp_q[LOW_W-1:0]);
  assign match_o = glb_en_i & tick_i & (m32_i ? eq_low : eq_full);

  assign adv_full = cmp_q + per_q;
  // narrow mode: wrap inside the low half, keep the high half
  assign adv_low  = {cmp_q[CNT_W-1 -: HI_W], cmp_q[LOW_W-1:0] + per_q[LOW_W-1:0]};
  assign adv      = m32_i ? adv_low : adv_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
      per_q <= '0;
    end else if (we_i) begin
      cmp_q <= wdata_i;
      if (periodic_i) per_q <= wdata_i;
    end else if (match_o && periodic_i) begin
      cmp_q <= adv;
    end
  end

  assign cmp_o = cmp_q;

  p_oneshot_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !periodic_i && !we_i) |=> cmp_q == $past(cmp_q));

  p_period_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && periodic_i && !we_i && !m32_i) |=> cmp_q == $past(cmp_q + per_q));

  p_narrow_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && periodic_i && !we_i && m32_i) |=>
      cmp_q[CNT_W-1 -: HI_W] == $past(cmp_q[CNT_W-1 -: HI_W]));

  p_write_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cmp_q == $past(wdata_i));
endmodule

// File: rtl/tmr_chan_irq.sv
module tmr_chan_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic clr_i,
  input  logic level_i,
  input  logic ie_i,
  output logic sts_o,
  output logic irq_o
);
  logic sts_q, edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      if (match_i)    sts_q <= 1'b1;
      else if (clr_i) sts_q <= 1'b0;
      edge_q <= match_i & ie_i & ~level_i;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = level_i ? (sts_q & ie_i) : edge_q;

  p_sts_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> sts_q);

  p_sts_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !match_i) |=> !sts_q);

  p_edge_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !level_i) |-> $past(match_i && ie_i));

  p_level_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i && ie_i && irq_o && !clr_i && $stable(level_i)) |=> (sts_q || !ie_i));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int LOW_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               glb_en_i,
  input  logic               cnt_tick_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic               cmp_we_i,
  input  logic [CNT_W-1:0]   cmp_wdata_i,
  input  logic               sts_clr_i,
  output logic [CFG_W-1:0]   cfg_o,
  output logic [CNT_W-1:0]   cmp_o,
  output logic [ROUTE_W-1:0] route_o,
  output logic               msg_en_o,
  output logic               sts_set_o,
  output logic               sts_o,
  output logic               irq_o
);
  cfg_t cfg;
  logic match;

  tmr_chan_cfg i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_o),
    .dec_o   (cfg)
  );

  tmr_chan_cmp #(.CNT_W(CNT_W), .LOW_W(LOW_W)) i_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .glb_en_i   (glb_en_i),
    .tick_i     (cnt_tick_i),
    .cnt_i      (cnt_i),
    .we_i       (cmp_we_i),
    .wdata_i    (cmp_wdata_i),
    .periodic_i (cfg.periodic),
    .m32_i      (cfg.m32),
    .cmp_o      (cmp_o),
    .match_o    (match)
  );

  tmr_chan_irq i_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (match),
    .clr_i   (sts_clr_i),
    .level_i (cfg.level),
    .ie_i    (cfg.ie),
    .sts_o   (sts_o),
    .irq_o   (irq_o)
  );

  assign sts_set_o = match;
  assign route_o   = cfg.route;
  assign msg_en_o  = cfg.msg_en;

  p_no_match_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_en_i || !cnt_tick_i) |-> !sts_set_o);
endmodule

// File: tb/test_tmr_chan.sv
`timescale 1ns/1ps
module test_tmr_chan;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        glb_en = 1'b0, tick = 1'b0, cfg_we = 1'b0, cmp_we = 1'b0, clr = 1'b0;
  logic [63:0] cnt = '0, cmp_wd = '0;
  logic [15:0] cfg_wd = '0;
  logic [15:0] cfg_o;
  logic [63:0] cmp_o;
  logic [4:0]  route_o;
  logic        msg_en_o, sts_set_o, sts_o, irq_o;

  always #4 clk = ~clk;

  tmr_chan i_tmr_chan (
    .clk_i(clk), .rst_ni(rst_ni), .glb_en_i(glb_en), .cnt_tick_i(tick), .cnt_i(cnt),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd),
    .sts_clr_i(clr), .cfg_o(cfg_o), .cmp_o(cmp_o), .route_o(route_o), .msg_en_o(msg_en_o),
    .sts_set_o(sts_set_o), .sts_o(sts_o), .irq_o(irq_o));

  // reference state
  logic [15:0] m_cfg = '0;
  logic [63:0] m_cmp = '1, m_per = '0;
  logic        m_sts = 1'b0, m_edge = 1'b0;
  int          n_chk = 0, n_bad = 0, fires = 0;
  string       scn = "R1";
  bit          done = 1'b0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", scn, what, act, exp);
    end
  endtask

  task automatic cyc();
    logic lvl, ie, per, m32, hit;
    logic [63:0] n_cmp, n_per;
    #1;
    lvl = m_cfg[1]; ie = m_cfg[2]; per = m_cfg[3]; m32 = m_cfg[8];
    hit = glb_en && tick && (m32 ? (cnt[31:0] == m_cmp[31:0]) : (cnt == m_cmp));
    chk("cfg_o R1", 64'(cfg_o), 64'(m_cfg));
    chk("route_o R1", 64'(route_o), 64'(m_cfg[13:9]));
    chk("msg_en_o R1", 64'(msg_en_o), 64'(m_cfg[14]));
    chk("cmp_o R6", cmp_o, m_cmp);
    chk("sts_set_o R2", 64'(sts_set_o), 64'(hit));
    chk("sts_o R4", 64'(sts_o), 64'(m_sts));
    chk(lvl ? "irq_o R8" : "irq_o R9", 64'(irq_o), 64'(lvl ? (m_sts & ie) : m_edge));
    if (sts_set_o) fires++;
    n_cmp = m_cmp; n_per = m_per;
    if (cmp_we) begin
      n_cmp = cmp_wd;
      if (per) n_per = cmp_wd;
    end else if (hit && per) begin
      if (m32) n_cmp = {m_cmp[63:32], m_cmp[31:0] + m_per[31:0]};
      else     n_cmp = m_cmp + m_per;
    end
    @(posedge clk);
    if (rst_ni) begin
      if (cfg_we) m_cfg = cfg_wd & 16'h7F0E;
      m_cmp = n_cmp; m_per = n_per;
      if (hit) m_sts = 1'b1; else if (clr) m_sts = 1'b0;
      m_edge = hit & ie & ~lvl;
    end
    @(negedge clk);
    cfg_we = 1'b0; cmp_we = 1'b0; clr = 1'b0;
  endtask

  task automatic wr_cfg(logic [15:0] v);
    cfg_we = 1'b1; cfg_wd = v; cyc();
  endtask

  task automatic wr_cmp(logic [63:0] v);
    cmp_we = 1'b1; cmp_wd = v; cyc();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      cyc();
      cnt = cnt + 1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    scn = "R1";
    cyc();                                   // reset values
    wr_cfg(16'hFFFF);
    cyc();
    wr_cfg(16'h4000 | (16'h13 << 9));
    cyc();

    // one-shot edge: single fire
    scn = "R5";
    wr_cfg(16'h0004);
    cnt = 0; wr_cmp(64'd20);
    glb_en = 1'b1; tick = 1'b1;
    fires = 0;
    run(40);
    chk("one-shot fire count R5", 64'(fires), 64'd1);
    chk("one-shot comparator R5", cmp_o, 64'd20);
    clr = 1'b1; cyc();

    // level mode holds until cleared
    scn = "R8";
    wr_cfg(16'h0006);
    cnt = 100; wr_cmp(64'd105);
    run(12);
    chk("level irq held R8", 64'(irq_o), 64'd1);
    clr = 1'b1; cyc();
    cyc();

    // status without enable, then clear colliding with match
    scn = "R4";
    wr_cfg(16'h0002);
    wr_cmp(cnt + 3);
    run(6);
    wr_cmp(cnt + 2);
    for (int i = 0; i < 5; i++) begin
      clr = 1'b1; cyc(); cnt = cnt + 1;
    end

    // qualifiers off
    scn = "R3";
    wr_cfg(16'h0004);
    wr_cmp(cnt + 2);
    glb_en = 1'b0;
    run(5);
    glb_en = 1'b1; tick = 1'b0;
    cnt = cmp_o;
    cyc(); cyc();
    chk("no status with tick low R3", 64'(sts_o), 64'd0);
    tick = 1'b1;

    // periodic
    scn = "R6";
    wr_cfg(16'h000C);
    cnt = 0; wr_cmp(64'd10);
    fires = 0;
    run(45);
    chk("periodic fire count R6", 64'(fires), 64'd4);
    chk("periodic comparator R6", cmp_o, 64'd50);
    wr_cfg(16'h0004);
    wr_cmp(64'd60);                          // one-shot write keeps period
    wr_cfg(16'h000C);
    cnt = 58;
    run(25);
    chk("advance with old period R6", cmp_o, 64'd90);

    // same-cycle write against periodic match
    scn = "R10";
    cnt = 80; wr_cmp(64'd80);
    cnt = 80; cmp_we = 1'b1; cmp_wd = 64'd200; cyc();
    chk("write beats advance R10", cmp_o, 64'd200);

    // back-to-back edge pulses
    scn = "R9";
    cnt = 0; wr_cmp(64'd1);
    cnt = 1;
    run(5);

    // forced 32-bit
    scn = "R7";
    wr_cfg(16'h010C);
    wr_cmp(64'h10);
    wr_cfg(16'h0104);
    wr_cmp(64'h0000_0009_FFFF_FFF8);
    wr_cfg(16'h010C);
    cnt = 64'h0000_0005_FFFF_FFF8;
    cyc();
    chk("narrow wrap R7", cmp_o, 64'h0000_0009_0000_0008);
    cnt = 64'h0000_0007_0000_0008;
    cyc();
    wr_cfg(16'h000C);
    cnt = 64'h0000_0007_0000_0018;
    cyc();
    chk("full width no match R7", cmp_o, 64'h0000_0009_0000_0018);

    finish_run();
  end
endmodule